// File: doc/BRIEF.md
# Static Memory Bus Sequencer

This block runs an asynchronous external memory bus for one internal requester. The requester raises a request carrying a chip-select index (0 to 5), a 9-bit halfword address, a read/write flag and 16-bit write data. It holds the request until a one-cycle acknowledge comes back; for reads, the data comes back with that acknowledge. On the external side the block drives six active-low chip selects, the address, active-low output-enable and write-enable strobes, and a 16-bit data bus. The data bus is split into output, output-enable and input so that the pad ring can build the tri-state buffer.

Each chip select has its own timing set, loaded through a small configuration port: a strobe width for reads and for writes, an extra latency on the first access to a page for reads and for writes, a write hold, and a bus recovery count. Each timing value is copied when an access starts, so a configuration write has no effect on an access already in progress. A page is an aligned group of 16 halfwords, selected by address bits [8:4].

Top module: `smem_seq`

## Requirements
- R1: While rst_ni is low, all chip selects, mem_oe_no and mem_we_no are high, mem_dq_oe_o is low and ack_o is low.
- R2: At most one chip select is low at any time. During an access, the one that is low is the one requested.
- R3: A read holds mem_oe_no low for read-wait+1 cycles. A write holds mem_we_no low for write-wait+1 cycles. The two strobes are never low together, and neither is low unless a chip select is low.
- R4: After every write, the chip select stays low and write data stays driven for write-hold+1 cycles after mem_we_no returns high.
- R5: After a read, the next access waits max(recovery,1) extra idle cycles, with all chip selects high, if it targets a different chip select or is a write. The recovery value used is the one of the chip select that was read. A read that follows a read on the same chip select gets no recovery.
- R6: The first access after reset, after a chip-select change, or after a change of address bits [8:4] keeps its chip select low for the first-access latency (the read or write value, 0 to 255) before its strobe starts. Other accesses start their strobe in the same cycle the chip select goes low.
- R7: ack_o is a single-cycle pulse in the cycle right after the last strobe cycle, before any hold cycles. For a read, rdata_o carries the bus value sampled in the last cycle of mem_oe_no low.
- R8: mem_dq_oe_o is high exactly while a chip select is low for a write (latency, strobe and hold cycles). It is low during reads and when the bus is idle.
- R9: A configuration write selects a field with cfg_fld_i: 0 read wait, 1 write wait, 2 read latency, 3 write latency, 4 write hold, 5 recovery. The 4-bit fields take bits [3:0] of cfg_val_i. A write that lands during an access takes effect only from the next access.
- R10: mem_addr_o equals the requested address and does not change while a chip select is low.
- R11: No new access starts until the write hold of the previous access has finished. After a write, the bus is idle for exactly one cycle when the next request is already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing register write strobe |
| cfg_cs_i | input | 3 | Chip select whose timing is written |
| cfg_fld_i | input | 3 | Timing field code |
| cfg_val_i | input | 8 | Field value |
| req_valid_i | input | 1 | Request present; held until ack_o |
| req_cs_i | input | 3 | Target chip select |
| req_addr_i | input | 9 | Halfword address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| ack_o | output | 1 | Access-phase completion pulse |
| rdata_o | output | 16 | Read data, valid with ack_o |
| mem_cs_no | output | 6 | Chip selects, active low |
| mem_addr_o | output | 9 | External address |
| mem_oe_no | output | 1 | Output enable strobe, active low |
| mem_we_no | output | 1 | Write enable strobe, active low |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | 16 | Data bus input value |

## Verification
The assertions check the cycle-level bus rules on every cycle. These are: a single active chip select, strobes never overlapping and never active without a chip select, the data driver enabled only for write cycles, the address held while a chip select is low, the chip select still low when the write strobe rises, and a one-cycle acknowledge. Some behaviour needs whole scenarios from the bench and a reference model of the timing registers: exact strobe, latency and hold lengths, whether recovery is inserted and how long it lasts across chip-select and read/write changes, page-change detection, correct read data through a modelled memory, and configuration writes taking effect only at the next access.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int CNT_W = 4;
  localparam int LAT_W = 8;
  localparam int FLD_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REC, ST_LAT, ST_STB, ST_HLD
  } st_e;

  typedef enum logic [FLD_W-1:0] {
    F_RD_WAIT = 3'd0,
    F_WR_WAIT = 3'd1,
    F_RD_LAT  = 3'd2,
    F_WR_LAT  = 3'd3,
    F_WR_HOLD = 3'd4,
    F_RECOV   = 3'd5
  } fld_e;

  typedef struct packed {
    logic [LAT_W-1:0] rd_lat;
    logic [LAT_W-1:0] wr_lat;
    logic [CNT_W-1:0] rd_wait;
    logic [CNT_W-1:0] wr_wait;
    logic [CNT_W-1:0] wr_hold;
    logic [CNT_W-1:0] recov;
  } tmg_t;
endpackage

// File: rtl/smem_cfg_bank.sv
module smem_cfg_bank import smem_pkg::*; #(
  parameter int NUM_CS = 6,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_cs_i,
  input  logic [FLD_W-1:0]  wr_fld_i,
  input  logic [LAT_W-1:0]  wr_val_i,
  output tmg_t              tmg_o [NUM_CS]
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    tmg_t t_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        t_q <= '0;
      end else if (wr_en_i && wr_cs_i == IDX_W'(g)) begin
        case (fld_e'(wr_fld_i))
          F_RD_WAIT: t_q.rd_wait <= wr_val_i[CNT_W-1:0];
          F_WR_WAIT: t_q.wr_wait <= wr_val_i[CNT_W-1:0];
          F_RD_LAT:  t_q.rd_lat  <= wr_val_i;
          F_WR_LAT:  t_q.wr_lat  <= wr_val_i;
          F_WR_HOLD: t_q.wr_hold <= wr_val_i[CNT_W-1:0];
          F_RECOV:   t_q.recov   <= wr_val_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
    assign tmg_o[g] = t_q;
  end
endmodule

// File: rtl/smem_cnt.sv
module smem_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/smem_seq.sv
module smem_seq import smem_pkg::*; #(
  parameter int NUM_CS   = 6,
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 16,
  parameter int PAGE_LSB = 4,
  localparam int IDX_W   = $clog2(NUM_CS),
  localparam int PAGE_W  = ADDR_W - PAGE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_cs_i,
  input  logic [FLD_W-1:0]  cfg_fld_i,
  input  logic [LAT_W-1:0]  cfg_val_i,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CS-1:0] mem_cs_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam logic [IDX_W-1:0] CS_MAX = IDX_W'(NUM_CS - 1);

  tmg_t cfg [NUM_CS];

  smem_cfg_bank #(.NUM_CS(NUM_CS)) u_cfg (
    .clk_i, .rst_ni,
    .wr_en_i (cfg_we_i),
    .wr_cs_i (cfg_cs_i),
    .wr_fld_i(cfg_fld_i),
    .wr_val_i(cfg_val_i),
    .tmg_o   (cfg)
  );

  st_e                st_q, st_d;
  logic [IDX_W-1:0]   cs_q, last_cs_q, req_idx;
  logic [PAGE_W-1:0]  last_page_q;
  logic               last_vld_q, last_rd_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q, first_q, ack_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic [LAT_W-1:0]   lat_q;
  logic [CNT_W-1:0]   wait_q, hold_q;

  logic               accept, req_first, need_rec, cnt_zero, cnt_load, strobe_end;
  logic [LAT_W-1:0]   cnt_val, rec_load, start_val, s_lat;
  logic [CNT_W-1:0]   s_wait, rec_prev;
  logic               s_first;
  st_e                start_st;

  assign req_idx   = (req_cs_i > CS_MAX) ? '0 : req_cs_i;
  assign accept    = (st_q == ST_IDLE) && req_valid_i && !ack_q;
  assign req_first = !last_vld_q || (req_idx != last_cs_q) ||
                     (req_addr_i[ADDR_W-1:PAGE_LSB] != last_page_q);
  // recovery only follows a read that changes chip select or turns to a write
  assign need_rec  = last_vld_q && last_rd_q && ((req_idx != last_cs_q) || req_write_i);
  assign rec_prev  = cfg[last_cs_q].recov;
  assign rec_load  = (rec_prev == '0) ? '0 : LAT_W'(rec_prev - 1'b1);

  // access-start parameters: live config in IDLE, snapshot after recovery
  always_comb begin
    if (st_q == ST_IDLE) begin
      s_lat   = req_write_i ? cfg[req_idx].wr_lat  : cfg[req_idx].rd_lat;
      s_wait  = req_write_i ? cfg[req_idx].wr_wait : cfg[req_idx].rd_wait;
      s_first = req_first;
    end else begin
      s_lat   = lat_q;
      s_wait  = wait_q;
      s_first = first_q;
    end
    if (s_first && s_lat != '0) begin
      start_st  = ST_LAT;
      start_val = s_lat - 1'b1;
    end else begin
      start_st  = ST_STB;
      start_val = LAT_W'(s_wait);
    end
  end

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (st_q)
      ST_IDLE: if (accept) begin
        cnt_load = 1'b1;
        if (need_rec) begin
          st_d    = ST_REC;
          cnt_val = rec_load;
        end else begin
          st_d    = start_st;
          cnt_val = start_val;
        end
      end
      ST_REC: if (cnt_zero) begin
        st_d     = start_st;
        cnt_load = 1'b1;
        cnt_val  = start_val;
      end
      ST_LAT: if (cnt_zero) begin
        st_d     = ST_STB;
        cnt_load = 1'b1;
        cnt_val  = LAT_W'(wait_q);
      end
      ST_STB: if (cnt_zero) begin
        if (wr_q) begin
          st_d     = ST_HLD;
          cnt_load = 1'b1;
          cnt_val  = LAT_W'(hold_q);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_HLD: if (cnt_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  smem_cnt #(.W(LAT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(cnt_load),
    .val_i (cnt_val),
    .zero_o(cnt_zero)
  );

  assign strobe_end = (st_q == ST_STB) && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cs_q        <= '0;
      addr_q      <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      first_q     <= 1'b0;
      lat_q       <= '0;
      wait_q      <= '0;
      hold_q      <= '0;
      last_cs_q   <= '0;
      last_page_q <= '0;
      last_vld_q  <= 1'b0;
      last_rd_q   <= 1'b0;
      ack_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      st_q  <= st_d;
      ack_q <= strobe_end;
      if (strobe_end && !wr_q) rdata_q <= mem_dq_i;
      if (accept) begin
        cs_q        <= req_idx;
        addr_q      <= req_addr_i;
        wr_q        <= req_write_i;
        wdata_q     <= req_wdata_i;
        first_q     <= req_first;
        lat_q       <= s_lat;
        wait_q      <= s_wait;
        hold_q      <= cfg[req_idx].wr_hold;
        last_cs_q   <= req_idx;
        last_page_q <= req_addr_i[ADDR_W-1:PAGE_LSB];
        last_vld_q  <= 1'b1;
        last_rd_q   <= !req_write_i;
      end
    end
  end

  logic bus_act;
  assign bus_act = (st_q == ST_LAT) || (st_q == ST_STB) || (st_q == ST_HLD);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
    assign mem_cs_no[g] = !(bus_act && cs_q == IDX_W'(g));
  end

  assign mem_addr_o  = addr_q;
  assign mem_oe_no   = !((st_q == ST_STB) && !wr_q);
  assign mem_we_no   = !((st_q == ST_STB) && wr_q);
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = bus_act && wr_q;
  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/smem_seq_chk.sv
module smem_seq_chk #(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] mem_cs_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              mem_dq_oe_o,
  input logic              ack_o
);
  logic cs_act;
  assign cs_act = !(&mem_cs_no);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_idle_chk: assert (&mem_cs_no && mem_oe_no && mem_we_no && !mem_dq_oe_o && !ack_o);
    end
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  // R3
  strobe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> cs_act);

  // R4
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (cs_act && mem_dq_oe_o));

  // R7
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R8
  dq_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (cs_act && mem_oe_no));

  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && $past(cs_act)) |-> $stable(mem_addr_o));
endmodule

bind smem_seq smem_seq_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_cs_no  (mem_cs_no),
  .mem_addr_o (mem_addr_o),
  .mem_oe_no  (mem_oe_no),
  .mem_we_no  (mem_we_no),
  .mem_dq_oe_o(mem_dq_oe_o),
  .ack_o      (ack_o)
);

// File: tb/smem_seq_tb_top.sv
`timescale 1ns/1ps
module smem_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_cs_i = '0;
  logic [2:0]  cfg_fld_i = '0;
  logic [7:0]  cfg_val_i = '0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_cs_i = '0;
  logic [8:0]  req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_wdata_i = '0;
  logic        ack_o;
  logic [15:0] rdata_o;
  logic [5:0]  mem_cs_no;
  logic [8:0]  mem_addr_o;
  logic        mem_oe_no, mem_we_no, mem_dq_oe_o;
  logic [15:0] mem_dq_o, mem_dq_i;

  always #4 clk_i = ~clk_i;

  smem_seq dut_i (.*);

  typedef struct {
    int cs; int addr; bit wr;
    int lat; int str; int hold; int gap;
    bit chk_gap; bit prev_rd; bit r9;
    logic [15:0] rd;
  } item_t;

  item_t q[$];
  int vec = 0, fail = 0;
  bit done = 0;
  logic [15:0] mdl [6][512];
  logic [15:0] ex_mem [6][512];
  int sh [6][6];
  bit h_vld = 0, h_rd = 0;
  int h_cs = 0, h_page = 0;

  task automatic chk(input string rq, input int act, input int exp);
    vec++;
    if (act != exp) begin
      fail++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic int cs_of(input logic [5:0] n);
    for (int i = 0; i < 6; i++) if (!n[i]) return i;
    return 0;
  endfunction

  // memory model
  always_comb mem_dq_i = !mem_oe_no ? mdl[cs_of(mem_cs_no)][mem_addr_o] : 16'hDEAD;

  task automatic set_cfg(input int cs, input int f, input int v);
    cfg_we_i = 1'b1; cfg_cs_i = 3'(cs); cfg_fld_i = 3'(f); cfg_val_i = 8'(v);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (cs < 6) sh[cs][f] = (f == 2 || f == 3) ? (v & 255) : (v & 15);
  endtask

  // driver: computes expected timing, pushes it, drives the request
  task automatic do_acc(input int cs, input int addr, input bit wr,
                        input logic [15:0] wd, input bit b2b, input bit r9 = 0);
    item_t it;
    bit first;
    int rec;
    first = !h_vld || cs != h_cs || (addr >> 4) != h_page;
    it.cs = cs; it.addr = addr; it.wr = wr; it.r9 = r9;
    it.lat  = first ? (wr ? sh[cs][3] : sh[cs][2]) : 0;
    it.str  = (wr ? sh[cs][1] : sh[cs][0]) + 1;
    it.hold = wr ? sh[cs][4] + 1 : 0;
    rec = (h_vld && h_rd && (cs != h_cs || wr)) ? ((sh[h_cs][5] == 0) ? 1 : sh[h_cs][5]) : 0;
    it.gap = (h_rd ? 2 : 1) + rec;
    it.chk_gap = b2b && h_vld;
    it.prev_rd = h_rd;
    it.rd = ex_mem[cs][addr];
    if (wr) ex_mem[cs][addr] = wd;
    h_vld = 1; h_rd = !wr; h_cs = cs; h_page = addr >> 4;
    q.push_back(it);
    req_valid_i = 1'b1; req_cs_i = 3'(cs); req_addr_i = 9'(addr);
    req_write_i = wr; req_wdata_i = wd;
    do @(negedge clk_i); while (!ack_o);
  endtask

  task automatic go_idle();
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  // monitor
  bit in_acc = 0, prev_strb = 0;
  int gap = 0, lat_n, str_n, hold_n, ack_n;
  bit seen;
  always @(negedge clk_i) begin
    bit cs_act, strb;
    if (rst_ni && !done) begin
      cs_act = !(&mem_cs_no);
      strb = !mem_oe_no || !mem_we_no;
      if (cs_act && !in_acc) begin
        in_acc = 1; lat_n = 0; str_n = 0; hold_n = 0; ack_n = 0; seen = 0;
        if (q.size() == 0) begin
          chk("R2 unexpected access", 1, 0);
        end else begin
          chk("R2 one cs", $countones(~mem_cs_no), 1);
          chk("R2 cs index", cs_of(mem_cs_no), q[0].cs);
          if (q[0].chk_gap) chk(q[0].prev_rd ? "R5 gap" : "R11 gap", gap, q[0].gap);
        end
      end
      if (in_acc && q.size() > 0) begin
        if (ack_o) begin
          ack_n++;
          if (!q[0].wr) chk("R7 rdata", int'(rdata_o), int'(q[0].rd));
        end
        if (prev_strb && !strb) chk("R7 ack after strobe", int'(ack_o), 1);
        if (cs_act) begin
          chk("R10 addr", int'(mem_addr_o), q[0].addr);
          chk("R8 dq_oe", int'(mem_dq_oe_o), int'(q[0].wr));
          if (!mem_we_no && mem_dq_oe_o) mdl[cs_of(mem_cs_no)][mem_addr_o] = mem_dq_o;
          if (strb) begin str_n++; seen = 1; end
          else if (!seen) lat_n++;
          else hold_n++;
        end else begin
          chk("R6 latency", lat_n, q[0].lat);
          chk(q[0].r9 ? "R9 strobe" : "R3 strobe", str_n, q[0].str);
          chk("R4 hold", hold_n, q[0].hold);
          chk("R7 ack count", ack_n, 1);
          void'(q.pop_front());
          in_acc = 0; gap = 0;
        end
      end else if (!in_acc && ack_o) begin
        chk("R7 stray ack", 1, 0);
      end
      if (!cs_act && !in_acc) gap++;
      prev_strb = strb;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 6; c++) begin
      for (int a = 0; a < 512; a++) begin
        mdl[c][a] = 16'((c * 16'h1111) ^ (a * 7 + 3));
        ex_mem[c][a] = mdl[c][a];
      end
      for (int f = 0; f < 6; f++) sh[c][f] = 0;
    end
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cs", int'(mem_cs_no), 63);
    chk("R1 oe/we", int'({mem_oe_no, mem_we_no}), 3);
    chk("R1 dq_oe", int'(mem_dq_oe_o), 0);
    chk("R1 ack", int'(ack_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    set_cfg(0, 0, 2); set_cfg(0, 1, 1); set_cfg(0, 2, 3);
    set_cfg(0, 3, 5); set_cfg(0, 4, 2); set_cfg(0, 5, 0);
    set_cfg(1, 5, 3);
    set_cfg(5, 0, 4); set_cfg(5, 5, 31); set_cfg(5, 2, 200);
    set_cfg(2, 0, 15); set_cfg(2, 4, 15);
    go_idle();

    // back-to-back group
    do_acc(0, 'h013, 1, 16'hA5A5, 1);
    do_acc(0, 'h014, 1, 16'h5A5A, 1);
    do_acc(0, 'h013, 0, 0, 1);
    do_acc(0, 'h012, 0, 0, 1);
    do_acc(0, 'h015, 1, 16'h1234, 1);
    do_acc(0, 'h123, 0, 0, 1);
    do_acc(1, 'h123, 0, 0, 1);
    do_acc(1, 'h040, 1, 16'hBEEF, 1);
    do_acc(1, 'h040, 0, 0, 1);
    do_acc(5, 'h1FF, 0, 0, 1);
    do_acc(0, 'h100, 0, 0, 1);
    do_acc(0, 'h015, 0, 0, 1);
    do_acc(2, 'h0F0, 1, 16'hCAFE, 1);
    do_acc(2, 'h0F0, 0, 0, 1);
    go_idle();

    // R9: config write during a long strobe applies only to the next access
    fork
      do_acc(2, 'h0F1, 0, 0, 0, 1);
      begin repeat (4) @(negedge clk_i); set_cfg(2, 0, 1); end
    join
    do_acc(2, 'h0F2, 0, 0, 1, 1);
    go_idle();

    repeat (5) @(negedge clk_i);
    chk("R2 queue drained", q.size(), 0);
    finish_run();
  end
endmodule